// File: doc/BRIEF.md
# ECC diagnostic error injection register

This block is the error-test register bank of an ECC-protected memory controller. Software uses it to raise single-bit or double-bit error requests toward the system manager without any involvement of the ECC decoder. Four test bits in the test register each stand for one error source:

- single-bit error
- double-bit error
- address mismatch
- address parity

Writing one to a test bit latches it and sets the matching flag in the status register. A single-bit flag drives `serr_req_o` directly.

The three double-class sources also set a hold bit. The hold bit drives `derr_req_o` and stays set until software clears it on its own. Clearing a status flag also clears the test bit that raised it. Real single-bit and double-bit events from the decoder enter on two pulse inputs. They set the same flags and requests as injected errors.

Top module: `ecc_diag_inject`

## Requirements
- R1: After reset, all test bits, all status flags, the hold bit, `serr_req_o` and `derr_req_o` are 0.
- R2: The test register is at offset 0x00. Bit 0 is the single-bit test, bit 8 the double-bit test, bit 16 the address-mismatch test and bit 24 the address-parity test. The status register is at 0x04, with bits 0..3 as the flags of those four sources in that order. The hold register is at 0x08, with the hold bit at bit 0. Every other bit, and every unmapped offset, reads 0 and ignores writes.
- R3: Writing 1 to test bit 0 sets that test bit and status bit 0 at the next clock edge. `serr_req_o` always equals status bit 0.
- R4: Writing 1 to test bit 8, 16 or 24 sets that test bit, the matching status bit 1, 2 or 3, and the hold bit at the next edge. `derr_req_o` follows the hold bit, so it rises in the cycle after the source fires.
- R5: Writing 1 to a status bit clears that flag and its test bit. Writing 0 to a status bit leaves it unchanged.
- R6: The hold bit and `derr_req_o` stay at 1 after the double-class flags are cleared. They drop only when 1 is written to hold bit 0.
- R7: Writing 0 to a test bit has no effect on it.
- R8: A pulse on `dec_serr_i` sets status bit 0. A pulse on `dec_derr_i` sets status bit 1 and the hold bit. Neither pulse changes any test bit.
- R9: When a source fires in the same cycle as a clear of its flag or of the hold bit, the flag or hold bit ends up set. In that case the source's test bit is not cleared either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte offset for read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| dec_serr_i | input | 1 | Decoder single-bit error pulse |
| dec_derr_i | input | 1 | Decoder double-bit error pulse |
| serr_req_o | output | 1 | Single-bit error request |
| derr_req_o | output | 1 | Double-bit error request |

## Verification
Assertions check every cycle that:
- a write of 1 to a test bit latches it and its flag;
- a clear with no competing set drops both the flag and the test bit;
- a set wins over a clear;
- idle test bits hold their value;
- the hold bit rises after a double-class source fires and persists until it is cleared.

Only the bench scenarios can show the rest:
- the register layout, including reserved bits and unmapped offsets reading zero;
- the separation between clearing the flags and clearing the hold bit;
- the decoder event paths, checked against a model over long random mixes of writes and events.

// File: rtl/ecc_diag_pkg.sv
package ecc_diag_pkg;
  localparam int DW     = 32;
  localparam int NSRC   = 4;
  localparam int STRIDE = 8;

  typedef enum logic [1:0] {
    SRC_SINGLE = 2'd0,
    SRC_DOUBLE = 2'd1,
    SRC_AMATCH = 2'd2,
    SRC_APAR   = 2'd3
  } src_e;

  function automatic int test_pos(input int idx);
    return idx * STRIDE;
  endfunction
endpackage

// File: rtl/ecc_diag_regif.sv
module ecc_diag_regif
  import ecc_diag_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] OFS_TEST = 'h00,
  parameter logic [ADDR_W-1:0] OFS_STAT = 'h04,
  parameter logic [ADDR_W-1:0] OFS_HOLD = 'h08
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [NSRC-1:0]   test_i,
  input  logic [NSRC-1:0]   flag_i,
  input  logic              hold_i,
  output logic [NSRC-1:0]   inject_o,
  output logic [NSRC-1:0]   clr_o,
  output logic              hold_clr_o,
  output logic [DW-1:0]     rdata_o
);
  logic hit_test, hit_stat, hit_hold;

  assign hit_test = wr_en_i && (addr_i == OFS_TEST);
  assign hit_stat = wr_en_i && (addr_i == OFS_STAT);
  assign hit_hold = wr_en_i && (addr_i == OFS_HOLD);

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      inject_o[i] = hit_test && wdata_i[test_pos(i)];
      clr_o[i]    = hit_stat && wdata_i[i];
    end
    hold_clr_o = hit_hold && wdata_i[0];
  end

  // reserved bits and unmapped offsets read zero
  always_comb begin
    rdata_o = '0;
    if (addr_i == OFS_TEST) begin
      for (int i = 0; i < NSRC; i++) rdata_o[test_pos(i)] = test_i[i];
    end else if (addr_i == OFS_STAT) begin
      rdata_o[NSRC-1:0] = flag_i;
    end else if (addr_i == OFS_HOLD) begin
      rdata_o[0] = hold_i;
    end
  end
endmodule

// File: rtl/ecc_diag_src.sv
module ecc_diag_src (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inject_i,
  input  logic event_i,
  input  logic clr_i,
  output logic test_o,
  output logic flag_o,
  output logic fire_o
);
  assign fire_o = inject_i | event_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      test_o <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      if (inject_i)                 test_o <= 1'b1;
      else if (clr_i && !event_i)   test_o <= 1'b0;  // set wins
      if (fire_o)                   flag_o <= 1'b1;
      else if (clr_i)               flag_o <= 1'b0;
    end
  end

  AST_INJ_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inject_i |=> (test_o && flag_o)); // R3
  AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !inject_i && !event_i) |=> (!test_o && !flag_o)); // R5
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && event_i) |=> flag_o); // R9
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inject_i && !clr_i) |=> $stable(test_o)); // R7
endmodule

// File: rtl/ecc_diag_hold.sv
module ecc_diag_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_o <= 1'b0;
    else if (set_i)  pend_o <= 1'b1;
    else if (clr_i)  pend_o <= 1'b0;
  end

  AST_DERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pend_o); // R4
  AST_DERR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !clr_i) |=> pend_o); // R6
endmodule

// File: rtl/ecc_diag_inject.sv
module ecc_diag_inject
  import ecc_diag_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              dec_serr_i,
  input  logic              dec_derr_i,
  output logic              serr_req_o,
  output logic              derr_req_o
);
  logic [NSRC-1:0] inject, clr, evt, fire, test, flag;
  logic            hold_clr, hold;

  always_comb begin
    evt             = '0;
    evt[SRC_SINGLE] = dec_serr_i;
    evt[SRC_DOUBLE] = dec_derr_i;
  end

  ecc_diag_regif #(.ADDR_W(ADDR_W)) u_regif (
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .test_i    (test),
    .flag_i    (flag),
    .hold_i    (hold),
    .inject_o  (inject),
    .clr_o     (clr),
    .hold_clr_o(hold_clr),
    .rdata_o   (rdata_o)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    ecc_diag_src u_src (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inject_i(inject[g]),
      .event_i (evt[g]),
      .clr_i   (clr[g]),
      .test_o  (test[g]),
      .flag_o  (flag[g]),
      .fire_o  (fire[g])
    );
  end

  ecc_diag_hold u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (|fire[NSRC-1:1]),
    .clr_i (hold_clr),
    .pend_o(hold)
  );

  assign serr_req_o = flag[SRC_SINGLE];
  assign derr_req_o = hold;
endmodule

// File: tb/ecc_diag_inject_tb.sv
module ecc_diag_inject_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        dserr = 1'b0, dderr = 1'b0;
  logic        serr_req, derr_req;

  int total = 0, bad = 0;
  logic [3:0] m_test = '0, m_flag = '0;
  logic       m_hold = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_diag_inject u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .dec_serr_i(dserr),
    .dec_derr_i(dderr), .serr_req_o(serr_req), .derr_req_o(derr_req)
  );

  function automatic logic [31:0] exp_test(input logic [3:0] t);
    logic [31:0] v = '0;
    for (int i = 0; i < 4; i++) v[i*8] = t[i];
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock of stimulus, model update per R3..R9
  task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d,
                     input logic ds, input logic dd);
    logic [3:0] inj, clr, ev, fire;
    @(negedge clk);
    wr_en = we; addr = a; wdata = d; dserr = ds; dderr = dd;
    @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      inj[i] = we && a == 8'h00 && d[i*8];
      clr[i] = we && a == 8'h04 && d[i];
    end
    ev = {2'b00, dd, ds};
    fire = inj | ev;
    for (int i = 0; i < 4; i++) begin
      if (inj[i]) m_test[i] = 1'b1;
      else if (clr[i] && !ev[i]) m_test[i] = 1'b0;
      if (fire[i]) m_flag[i] = 1'b1;
      else if (clr[i]) m_flag[i] = 1'b0;
    end
    if (|fire[3:1]) m_hold = 1'b1;
    else if (we && a == 8'h08 && d[0]) m_hold = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; dserr = 1'b0; dderr = 1'b0;
  endtask

  task automatic check_all(input string req);
    addr = 8'h00; #1 chk({req, " test"}, rdata, exp_test(m_test));
    addr = 8'h04; #1 chk({req, " stat"}, rdata, {28'd0, m_flag});
    addr = 8'h08; #1 chk({req, " hold"}, rdata, {31'd0, m_hold});
    chk({req, " serr"}, {31'd0, serr_req}, {31'd0, m_flag[0]});
    chk({req, " derr"}, {31'd0, derr_req}, {31'd0, m_hold});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);

    cyc(1, 8'h00, 32'h0000_0001, 0, 0); check_all("R3");
    cyc(1, 8'h04, 32'h0000_0000, 0, 0); check_all("R5 zero");
    cyc(1, 8'h04, 32'h0000_0001, 0, 0); check_all("R5");
    cyc(1, 8'h00, 32'h0000_0100, 0, 0); check_all("R4 dbl");
    cyc(1, 8'h00, 32'h0001_0000, 0, 0); check_all("R4 amatch");
    cyc(1, 8'h00, 32'h0100_0000, 0, 0); check_all("R4 apar");
    cyc(1, 8'h00, 32'h0000_0000, 0, 0); check_all("R7");
    cyc(1, 8'h04, 32'h0000_000e, 0, 0); check_all("R6 flags cleared");
    cyc(1, 8'h08, 32'h0000_0001, 0, 0); check_all("R6 hold cleared");
    cyc(1, 8'h00, 32'hfefe_fefe, 0, 0); check_all("R2 reserved");
    addr = 8'h0c; #1 chk("R2 unmapped", rdata, 32'd0);
    cyc(1, 8'h0c, 32'hffff_ffff, 0, 0); check_all("R2 unmapped write");
    cyc(0, 8'h00, 32'h0, 1, 1); check_all("R8");
    cyc(1, 8'h04, 32'h0000_0003, 1, 1); check_all("R9 flag");
    cyc(1, 8'h08, 32'h0000_0001, 0, 1); check_all("R9 hold");
    cyc(1, 8'h00, 32'h0000_0101, 0, 0);
    cyc(1, 8'h04, 32'h0000_0003, 1, 0); check_all("R9 test kept");

    for (int n = 0; n < 2000; n++) begin
      logic [1:0] op = 2'($urandom_range(0, 3));
      logic [31:0] d = $urandom();
      logic [7:0] a = (op == 0) ? 8'h00 : (op == 1) ? 8'h04 : (op == 2) ? 8'h08 : 8'h0c;
      cyc($urandom_range(0, 1) == 1, a, d,
          $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0);
      check_all("R3-mix R4 R5 R6 R8 R9");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule